// File: doc/BRIEF.md
# Two-Wire Bus Condition and Wake-Up Controller

This block is the control and status unit beside the 8-bit shift register of a two-wire serial port. Software uses it to put start and stop conditions on the bus. It does this through two self-clearing command bits that steer the serial data output latch. The block also watches the data and clock lines through a synchronizer and records start and stop conditions in read-only flags.

Each completed byte can raise an interrupt pulse. In wake-up mode the pulse is held back unless the byte is the first one after a detected start and the shift register then holds the programmed slave address. A host reaches four 8-bit registers through a simple bus that supports whole-byte writes and single-bit writes. Read data is combinational from the address.

Register addresses: 0 is control, 1 is mode, 2 is slave address and 3 is the shift-register window. Control bits, from 7 down to 0: busy-enable (rw), ack-seen (ro, mirrors the `ack_seen` input), ack-enable (rw), ack-trigger (rw), start-seen (ro), stop-seen (ro), start-command, stop-command. Mode bits: 7 is port enable (rw), 6 is address match (ro), 5 is wake-up (rw) and 0 is misuse error (ro). Bits 4 to 1 of the mode register read 0.

Top module: `twi_cond_wake`

## Requirements
- R1: A write of 1 to control bit 0 while the port is enabled makes that bit read 1 for one cycle. In the next cycle `so_latch` becomes 1 and the bit reads 0 again.
- R2: A write of 1 to control bit 1 while enabled drives `so_latch` to 0 in the same way. If bits 0 and 1 are written together, the stop command wins and `so_latch` becomes 1.
- R3: While mode bit 7 is 0, both command bits stay 0 and command writes leave `so_latch` unchanged.
- R4: Control bit 2 is set 3 cycles after SDA rises while SCL is high. It is cleared by an accepted shift-register write, by a mismatching first byte after a start, and by port disable.
- R5: Control bit 3 is set 3 cycles after SDA falls while SCL is high. It clears only on port disable or reset.
- R6: Mode bit 6 reads 1 exactly when the port is enabled and the slave address register equals `shreg_data`.
- R7: With wake-up off and the port enabled, each `byte_done` pulse gives a one-cycle `irq` pulse in the next cycle. No pulse is given while the port is disabled.
- R8: With wake-up on, `irq` pulses only for the first `byte_done` after a detected start, and only if mode bit 6 is 1 in that cycle.
- R9: After reset, control reads 00h, `so_latch` is 1 and the mode bits read 0. Writes to control bits 6, 3 and 2 and to mode bits 6 and 0 are ignored.
- R10: A byte write to address 3 while the port is enabled and wake-up is off gives a `shift_load` pulse in the same cycle. With wake-up on there is no pulse and mode bit 0 is set. With the port disabled there is no pulse.
- R11: A bit write changes only the selected bit of the addressed register and keeps all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_bit_wr | input | 1 | Single-bit write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_sel | input | 3 | Bit position for a bit write |
| bus_bit_val | input | 1 | Value for a bit write |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sda_in | input | 1 | Data line level |
| scl_in | input | 1 | Clock line level |
| ack_seen | input | 1 | Acknowledge status from the acknowledge logic |
| shreg_data | input | 8 | Current shift register contents |
| byte_done | input | 1 | One-cycle pulse when a byte transfer completes |
| so_latch | output | 1 | Serial data output latch |
| shift_load | output | 1 | Accepted load strobe for the shift register |
| shift_wdata | output | 8 | Data to load into the shift register |
| irq | output | 1 | Transfer interrupt pulse |

## Verification
Some properties are checked on every cycle by assertions. Each command sets the latch one cycle later, and the latch does not move when no command is pending. Both command bits read 0 while the port is off, and disabling the port clears the condition flags. Every interrupt follows an enabled byte completion, and in wake-up mode it also follows an address match. A misused shift write sets the error flag.

Other behaviour can only be shown by the bench's scenarios, because it depends on sequences. These cover the three-cycle detection delay for start and stop, and the rule that only the first byte after a start may raise an interrupt in wake-up mode. They also cover the clearing of the stop flag by a mismatching address, the read-only bits, and bit writes leaving neighbouring bits untouched.

// File: rtl/twi_cw_pkg.sv
package twi_cw_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_MODE  = 2'd1,
        RA_SLAVE = 2'd2,
        RA_SHIFT = 2'd3
    } reg_addr_e;

    // control register bit positions (software decodes these)
    localparam int C_STOP_CMD  = 0;
    localparam int C_START_CMD = 1;
    localparam int C_STOP_SEEN = 2;
    localparam int C_START_SEEN= 3;
    localparam int C_ACK_TRIG  = 4;
    localparam int C_ACK_EN    = 5;
    localparam int C_ACK_SEEN  = 6;
    localparam int C_BUSY_EN   = 7;

    // mode register bit positions
    localparam int M_ERR   = 0;
    localparam int M_WAKE  = 5;
    localparam int M_MATCH = 6;
    localparam int M_EN    = 7;

    typedef struct packed {
        logic busy_en;
        logic ack_en;
        logic ack_trig;
    } ctrl_cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] val;
        reg_addr_e        addr;
    } bus_op_t;

    function automatic logic [REG_W-1:0] op_mask(input logic byte_wr,
                                                 input logic bit_wr,
                                                 input logic [2:0] sel);
        if (byte_wr)     return '1;
        else if (bit_wr) return REG_W'(1) << sel;
        else             return '0;
    endfunction

    function automatic logic [REG_W-1:0] op_val(input logic byte_wr,
                                                input logic [REG_W-1:0] wdata,
                                                input logic bit_val);
        return byte_wr ? wdata : {REG_W{bit_val}};
    endfunction

    function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old,
                                               input logic [REG_W-1:0] mask,
                                               input logic [REG_W-1:0] val);
        return (old & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sda_in,
    input  logic     scl_in,
    output line_ev_t ev
);
    localparam int LAST = STAGES - 1;

    // bit 1 = SCL, bit 0 = SDA; idle bus is high
    logic [1:0] pipe [STAGES];
    logic [1:0] prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 2'b11;
                else     pipe[g] <= {scl_in, sda_in};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 2'b11;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b11;
        else     prev <= pipe[LAST];
    end

    always_comb begin
        ev.start = prev[0] & ~pipe[LAST][0] & pipe[LAST][1];
        ev.stop  = ~prev[0] & pipe[LAST][0] & pipe[LAST][1];
    end

endmodule

// File: rtl/twi_cw_regs.sv
module twi_cw_regs
    import twi_cw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  line_ev_t         ev,
    input  logic             load,
    input  logic             misuse,
    input  logic             addr_miss,
    output logic             en,
    output logic             wake,
    output logic             err,
    output logic [REG_W-1:0] slave,
    output ctrl_cfg_t        cfg,
    output logic             start_seen,
    output logic             stop_seen,
    output logic             start_cmd,
    output logic             stop_cmd,
    output logic             so_latch
);
    logic hit_ctrl, hit_mode, hit_slave;

    always_comb begin
        hit_ctrl  = (op.addr == RA_CTRL)  && (|op.mask);
        hit_mode  = (op.addr == RA_MODE)  && (|op.mask);
        hit_slave = (op.addr == RA_SLAVE) && (|op.mask);
    end

    // command bits: live one cycle, then applied to the latch
    always_ff @(posedge clk) begin
        if (rst) begin
            stop_cmd  <= 1'b0;
            start_cmd <= 1'b0;
            so_latch  <= 1'b1;
        end else begin
            stop_cmd  <= en & hit_ctrl & op.mask[C_STOP_CMD]  & op.val[C_STOP_CMD];
            start_cmd <= en & hit_ctrl & op.mask[C_START_CMD] & op.val[C_START_CMD];
            if (stop_cmd)       so_latch <= 1'b1;
            else if (start_cmd) so_latch <= 1'b0;
        end
    end

    // writable configuration bits of the control register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (hit_ctrl) begin
            if (op.mask[C_BUSY_EN])  cfg.busy_en  <= op.val[C_BUSY_EN];
            if (op.mask[C_ACK_EN])   cfg.ack_en   <= op.val[C_ACK_EN];
            if (op.mask[C_ACK_TRIG]) cfg.ack_trig <= op.val[C_ACK_TRIG];
        end
    end

    // status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            err        <= 1'b0;
        end else if (!en) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            err        <= 1'b0;
        end else begin
            if (ev.start) start_seen <= 1'b1;
            if (ev.stop)                  stop_seen <= 1'b1;
            else if (load || addr_miss)   stop_seen <= 1'b0;
            if (misuse) err <= 1'b1;
        end
    end

    // mode and slave address
    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            wake  <= 1'b0;
            slave <= '0;
        end else begin
            if (hit_mode && op.mask[M_EN])   en   <= op.val[M_EN];
            if (hit_mode && op.mask[M_WAKE]) wake <= op.val[M_WAKE];
            if (hit_slave) slave <= merge(slave, op.mask, op.val);
        end
    end

    p_stop_sets_latch_r1: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> so_latch);
    p_latch_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (!stop_cmd && !start_cmd) |=> $stable(so_latch));
    p_start_clears_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (start_cmd && !stop_cmd) |=> !so_latch);
    p_cmds_idle_off_r3: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!start_cmd && !stop_cmd));
    p_flags_drop_off_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!start_seen && !stop_seen && !err));
    p_misuse_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (misuse && en) |=> err);

endmodule

// File: rtl/twi_wake_gate.sv
module twi_wake_gate
    import twi_cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     wake,
    input  logic     match,
    input  line_ev_t ev,
    input  logic     byte_done,
    output logic     addr_miss,
    output logic     irq
);
    logic await_addr;

    assign addr_miss = en & byte_done & await_addr & ~match;

    always_ff @(posedge clk) begin
        if (rst) begin
            await_addr <= 1'b0;
            irq        <= 1'b0;
        end else begin
            irq <= en & byte_done & (~wake | (await_addr & match));
            if (!en)            await_addr <= 1'b0;
            else if (ev.start)  await_addr <= 1'b1;
            else if (byte_done) await_addr <= 1'b0;
        end
    end

    p_irq_from_byte_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(byte_done && en));
    p_wake_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(wake)) |-> $past(match && await_addr));

endmodule

// File: rtl/twi_cond_wake.sv
module twi_cond_wake
    import twi_cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_bit_wr,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [2:0]       bus_bit_sel,
    input  logic             bus_bit_val,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             ack_seen,
    input  logic [REG_W-1:0] shreg_data,
    input  logic             byte_done,
    output logic             so_latch,
    output logic             shift_load,
    output logic [REG_W-1:0] shift_wdata,
    output logic             irq
);
    bus_op_t          op;
    line_ev_t         ev;
    ctrl_cfg_t        cfg;
    logic             en, wake, err, match, misuse, addr_miss;
    logic             start_seen, stop_seen, start_cmd, stop_cmd;
    logic [REG_W-1:0] slave;
    logic             shift_wr;

    always_comb begin
        op.mask = op_mask(bus_wr, bus_bit_wr, bus_bit_sel);
        op.val  = op_val(bus_wr, bus_wdata, bus_bit_val);
        op.addr = reg_addr_e'(bus_addr);
    end

    assign shift_wr    = bus_wr && (op.addr == RA_SHIFT) && en;
    assign shift_load  = shift_wr && !wake;
    assign misuse      = shift_wr && wake;
    assign shift_wdata = bus_wdata;
    assign match       = en && (slave == shreg_data);

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sda_in (sda_in),
        .scl_in (scl_in),
        .ev     (ev)
    );

    twi_cw_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .ev         (ev),
        .load       (shift_load),
        .misuse     (misuse),
        .addr_miss  (addr_miss),
        .en         (en),
        .wake       (wake),
        .err        (err),
        .slave      (slave),
        .cfg        (cfg),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .so_latch   (so_latch)
    );

    twi_wake_gate u_wake (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .wake      (wake),
        .match     (match),
        .ev        (ev),
        .byte_done (byte_done),
        .addr_miss (addr_miss),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (op.addr)
            RA_CTRL: begin
                bus_rdata[C_BUSY_EN]    = cfg.busy_en;
                bus_rdata[C_ACK_SEEN]   = ack_seen;
                bus_rdata[C_ACK_EN]     = cfg.ack_en;
                bus_rdata[C_ACK_TRIG]   = cfg.ack_trig;
                bus_rdata[C_START_SEEN] = start_seen;
                bus_rdata[C_STOP_SEEN]  = stop_seen;
                bus_rdata[C_START_CMD]  = start_cmd;
                bus_rdata[C_STOP_CMD]   = stop_cmd;
            end
            RA_MODE: begin
                bus_rdata[M_EN]    = en;
                bus_rdata[M_MATCH] = match;
                bus_rdata[M_WAKE]  = wake;
                bus_rdata[M_ERR]   = err;
            end
            RA_SLAVE: bus_rdata = slave;
            RA_SHIFT: bus_rdata = shreg_data;
            default:  bus_rdata = '0;
        endcase
    end

    p_load_needs_awake_off_r10: assert property (@(posedge clk) disable iff (rst)
        shift_load |=> !err || $past(err));

endmodule

// File: tb/test_twi_cond_wake.sv
`timescale 1ns/1ps
module test_twi_cond_wake;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_bit_wr = 1'b0, bus_bit_val = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [2:0] bus_bit_sel = 3'd0;
    logic [7:0] bus_rdata;
    logic       sda_in = 1'b1, scl_in = 1'b1, ack_seen = 1'b0;
    logic [7:0] shreg_data = 8'h00;
    logic       byte_done = 1'b0;
    logic       so_latch, shift_load, irq;
    logic [7:0] shift_wdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    bit m_valid = 1'b0;

    always #2 clk = ~clk;

    twi_cond_wake i_twi_cond_wake (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_bit_wr(bus_bit_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_bit_sel(bus_bit_sel), .bus_bit_val(bus_bit_val),
        .bus_rdata(bus_rdata), .sda_in(sda_in), .scl_in(scl_in),
        .ack_seen(ack_seen), .shreg_data(shreg_data), .byte_done(byte_done),
        .so_latch(so_latch), .shift_load(shift_load), .shift_wdata(shift_wdata),
        .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic m_en, m_wake, m_err, m_busy, m_acken, m_acktrig;
    logic m_sstart, m_sstop, m_cstart, m_cstop, m_latch, m_await, m_irq;
    logic [7:0] m_slave;
    logic [1:0] m_line_q[$];   // {scl,sda} history, newest at back
    logic [1:0] m_prev;

    always @(posedge clk) begin : model
        logic [7:0] mk, vl;
        logic [1:0] cur;
        logic hc, hm, hs, st_ev, sp_ev, mt, ld, mis, miss;
        if (rst) begin
            {m_en, m_wake, m_err, m_busy, m_acken, m_acktrig} = '0;
            {m_sstart, m_sstop, m_cstart, m_cstop, m_await, m_irq} = '0;
            m_latch = 1'b1;
            m_slave = 8'h00;
            m_line_q = '{2'b11, 2'b11};
            m_prev = 2'b11;
        end else begin
            mk = bus_wr ? 8'hFF : (bus_bit_wr ? (8'h01 << bus_bit_sel) : 8'h00);
            vl = bus_wr ? bus_wdata : {8{bus_bit_val}};
            hc = (mk != 0) && bus_addr == 2'd0;
            hm = (mk != 0) && bus_addr == 2'd1;
            hs = (mk != 0) && bus_addr == 2'd2;
            cur = m_line_q[0];
            st_ev = m_prev[0] && !cur[0] && cur[1];
            sp_ev = !m_prev[0] && cur[0] && cur[1];
            mt   = m_en && (m_slave == shreg_data);
            ld   = bus_wr && bus_addr == 2'd3 && m_en && !m_wake;
            mis  = bus_wr && bus_addr == 2'd3 && m_en && m_wake;
            miss = m_en && byte_done && m_await && !mt;
            // latch follows last cycle's command (R1, R2)
            if (m_cstop) m_latch = 1'b1;
            else if (m_cstart) m_latch = 1'b0;
            m_irq = m_en && byte_done && (!m_wake || (m_await && mt));
            if (!m_en) begin
                {m_sstart, m_sstop, m_err, m_await} = '0;
            end else begin
                if (st_ev) m_sstart = 1'b1;
                if (sp_ev) m_sstop = 1'b1;
                else if (ld || miss) m_sstop = 1'b0;
                if (mis) m_err = 1'b1;
                if (st_ev) m_await = 1'b1;
                else if (byte_done) m_await = 1'b0;
            end
            m_cstop  = m_en && hc && mk[0] && vl[0];
            m_cstart = m_en && hc && mk[1] && vl[1];
            if (hc && mk[7]) m_busy = vl[7];
            if (hc && mk[5]) m_acken = vl[5];
            if (hc && mk[4]) m_acktrig = vl[4];
            if (hm && mk[7]) m_en = vl[7];
            if (hm && mk[5]) m_wake = vl[5];
            for (int b = 0; b < 8; b++) if (hs && mk[b]) m_slave[b] = vl[b];
            m_prev = cur;
            void'(m_line_q.pop_front());
            m_line_q.push_back({scl_in, sda_in});
            m_valid = 1'b1;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (m_valid && !finished) begin
            logic [7:0] exp_rd;
            vectors++;
            case (bus_addr)
                2'd0: exp_rd = {m_busy, ack_seen, m_acken, m_acktrig,
                                m_sstart, m_sstop, m_cstart, m_cstop};
                2'd1: exp_rd = {m_en, m_en && (m_slave == shreg_data), m_wake, 4'b0, m_err};
                2'd2: exp_rd = m_slave;
                default: exp_rd = shreg_data;
            endcase
            check("R1 R2 R3 (so_latch)", {7'b0, so_latch}, {7'b0, m_latch});
            check("R7 R8 (irq)", {7'b0, irq}, {7'b0, m_irq});
            check("R10 (shift_load)", {7'b0, shift_load},
                  {7'b0, bus_wr && bus_addr == 2'd3 && m_en && !m_wake});
            check("R10 (shift_wdata)", shift_wdata, bus_wdata);
            case (bus_addr)
                2'd0: check("R1 R2 R3 R4 R5 R9 R11 (control read)", bus_rdata, exp_rd);
                2'd1: check("R6 R9 R10 R11 (mode read)", bus_rdata, exp_rd);
                2'd2: check("R11 (slave read)", bus_rdata, exp_rd);
                default: check("R6 (shift window read)", bus_rdata, exp_rd);
            endcase
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk);
        bus_wr = 1'b0; bus_bit_wr = 1'b0; byte_done = 1'b0;
    endtask
    task automatic idle(input int n); repeat (n) cyc(); endtask
    task automatic wb(input logic [1:0] a, input logic [7:0] d);
        cyc(); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask
    task automatic wbit(input logic [1:0] a, input logic [2:0] s, input logic v);
        cyc(); bus_bit_wr = 1'b1; bus_addr = a; bus_bit_sel = s; bus_bit_val = v;
    endtask
    task automatic look(input logic [1:0] a); cyc(); bus_addr = a; endtask
    task automatic lines(input logic c, input logic d); cyc(); scl_in = c; sda_in = d; endtask
    task automatic done_pulse(); cyc(); byte_done = 1'b1; endtask
    task automatic start_cond(); lines(1, 1); idle(2); lines(1, 0); idle(4); endtask
    task automatic stop_cond();  lines(1, 0); idle(2); lines(1, 1); idle(4); endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R9: reset values of every register
        look(0); look(1); look(2); look(3);
        // R3: commands ignored while disabled
        wb(0, 8'h02); look(0); idle(2);
        // enable the port
        wb(1, 8'h80); look(1);
        // R9: read-only bits ignore writes; R2: both commands, stop wins
        wb(0, 8'hFF); look(0); idle(2);
        wb(0, 8'h00);
        // R2 then R1 via bit writes
        wbit(0, 3'd1, 1'b1); look(0); idle(2);
        wbit(0, 3'd0, 1'b1); look(0); idle(2);
        // R11: single bit writes to slave and control
        wb(2, 8'h5A); wbit(2, 3'd0, 1'b1); look(2); wbit(2, 3'd6, 1'b0); look(2);
        wbit(0, 3'd5, 1'b1); look(0); wbit(0, 3'd6, 1'b1); look(0);
        wbit(1, 3'd6, 1'b1); look(1); wbit(1, 3'd0, 1'b1); look(1);
        wb(2, 8'h5A);
        // R5, R4: condition detection
        look(0); start_cond(); stop_cond();
        // R10: shift write with wake off clears stop flag
        wb(3, 8'h11); look(0);
        // R6: address match flag
        shreg_data = 8'h5A; look(1); shreg_data = 8'h33; look(1);
        // R7: wake off, each byte gives irq
        done_pulse(); idle(1); done_pulse(); done_pulse(); idle(2);
        // R8: wake on, first byte after start with matching address
        wb(1, 8'hA0); look(1);
        shreg_data = 8'h5A; done_pulse(); idle(2);
        start_cond(); done_pulse(); idle(1); done_pulse(); idle(2);
        // R8, R4: mismatching address clears stop flag, no irq
        stop_cond(); look(0); start_cond(); shreg_data = 8'h33; done_pulse(); look(0); idle(2);
        // R10: shift write in wake mode is refused and flagged
        wb(3, 8'h44); look(1); idle(1);
        // R3, R5: disabling clears flags and blocks commands and irq
        wb(1, 8'h00); look(0); look(1); wb(0, 8'h01); look(0); done_pulse(); idle(2);
        wb(3, 8'h22); idle(2);
        // randomized traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            cyc();
            r = $urandom_range(0, 31);
            bus_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) scl_in = ~scl_in;
            if ($urandom_range(0, 3) == 0) sda_in = ~sda_in;
            if ($urandom_range(0, 7) == 0) byte_done = 1'b1;
            if ($urandom_range(0, 9) == 0) ack_seen = ~ack_seen;
            if ($urandom_range(0, 11) == 0) shreg_data = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'h33;
            if (r == 0) begin
                bus_wr = 1'b1; bus_addr = 2'd1;
                bus_wdata = {($urandom_range(0, 7) != 0), 1'b1, 1'($urandom_range(0, 1)),
                             5'($urandom_range(0, 31))};
            end else if (r < 4) begin
                bus_wr = 1'b1; bus_wdata = 8'($urandom_range(0, 255));
                bus_addr = (r == 1) ? 2'd0 : (r == 2) ? 2'd3 : 2'd2;
                if (r == 3) bus_wdata = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'h33;
            end else if (r < 7) begin
                bus_bit_wr = 1'b1; bus_addr = 2'($urandom_range(0, 2));
                bus_bit_sel = 3'($urandom_range(0, 7));
                bus_bit_val = 1'($urandom_range(0, 1));
                if (bus_addr == 2'd1 && bus_bit_sel == 3'd7) bus_bit_val = 1'b1;
            end
        end
        idle(3);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule